// File: doc/BRIEF.md
# Reversible SR Latch Step Model

This block models, one clock edge per gate-processing step, a set/reset latch whose combinational part is a pair of three-input reversible gates and whose state closes through feedback. Each edge the gate pair computes a new Q / Qbar pair from the present pair and the two command pins. That new pair is written into the state register and offered to the gates again on the next edge. Because the model is stepped rather than instantly settled, it shows every transient: intermediate pairs, extra settling steps and endless oscillation.

A parameter chooses the gate family. In the controlled-swap variant, each gate takes one state line as its control and carries a constant-1 line. The fed-back line is inverted, so the pair acts as a cross-coupled NOR, with active-high set and clear pins. In the controlled-XOR variant, each gate takes a command pin and a state line as its two controls and a constant-1 target. The pair acts as a cross-coupled NAND, with active-low set and clear pins.

The second data output of each gate leaves the block as a spill line. A settled flag reports that the stored pair did not change on the last step. The block has no data stream, so every pin is a plain level.

Top module: `revlatch_stepper`

## Requirements
- R1: A synchronous reset, sampled at a clock edge, loads Q=0, Qbar=1 and makes `settled` high after that edge.
- R2: Swap variant (GATE_KIND=0): each step computes next Q = NOT(Qbar OR clear) and next Qbar = NOT(Q OR set), with active-high pins.
- R3: XOR variant (GATE_KIND=1): each step computes next Q = set OR NOT Qbar and next Qbar = clear OR NOT Q, where set and clear are the asserted (low) pin levels.
- R4: With neither command asserted, a stored pair of 01 or 10 is kept unchanged on every step.
- R5: With neither command asserted, a stored pair of 00 or 11 toggles to the other of those two on every step, a period of 2.
- R6: With only clear asserted, the pair reaches 01 within two steps from any start. With only set asserted, it reaches 10 within two steps.
- R7: For each variant, exactly two of the four start pairs need the second step for set, and exactly two need it for clear. Swap variant: set is slow from 01 and 11, clear from 10 and 11. XOR variant: set is slow from 00 and 01, clear from 00 and 10.
- R8: With both commands asserted, the pair becomes 00 after one step on the swap variant and 11 on the XOR variant.
- R9: `settled` is high exactly when the present pair equals the pair held one step earlier.
- R10: The spill lines are combinational from the present pair and pins. Swap variant: spill_a = NOT Qbar OR clear and spill_b = NOT Q OR set. XOR variant: spill_a = Qbar and spill_b = Q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock; one gate-processing step per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| set_pin | input | 1 | Set command (active high on swap variant, active low on XOR variant) |
| clr_pin | input | 1 | Clear command (same polarity rule as set_pin) |
| q | output | 1 | Stored Q |
| q_n | output | 1 | Stored Qbar |
| spill_a | output | 1 | Second data output of the Q-side gate |
| spill_b | output | 1 | Second data output of the Qbar-side gate |
| settled | output | 1 | Pair unchanged over the last step |

## Verification
The synchronous reset and a latch command can land on the same edge. The settled flag can also change on the same edge that a command moves the pair. Random stimulus raises `rst` while set, clear or both are driven, and expects the reset load to win and `settled` to read high on the following sample. On every other edge, a bench model of the step equations predicts the pair, the spill lines and the flag. Directed sweeps first steer each variant into each of the four start pairs, then apply every command combination and judge the settling step count and the oscillation period.

// File: rtl/revlatch_pkg.sv
`timescale 1ns/1ps
package revlatch_pkg;
  localparam int KIND_SWAP = 0;
  localparam int KIND_XOR  = 1;

  typedef struct packed {
    logic q;
    logic qn;
  } pair_t;

  localparam pair_t PAIR_RESET = '{q: 1'b0, qn: 1'b1};
endpackage

// File: rtl/rl_cswap_gate.sv
`timescale 1ns/1ps
// Controlled swap: the control line passes through at the caller;
// the two data lines exchange when the control is 1.
module rl_cswap_gate (
  input  logic ctl,
  input  logic a,
  input  logic b,
  output logic a_o,
  output logic b_o
);
  always_comb begin
    a_o = ctl ? b : a;
    b_o = ctl ? a : b;
  end
endmodule

// File: rtl/rl_cxor_gate.sv
`timescale 1ns/1ps
// Controlled XOR: both controls pass through at the caller;
// the target flips when both controls are 1.
module rl_cxor_gate (
  input  logic c1,
  input  logic c2,
  input  logic t,
  output logic t_o
);
  always_comb t_o = (c1 & c2) ^ t;
endmodule

// File: rtl/rl_gate_pair.sv
`timescale 1ns/1ps
module rl_gate_pair
  import revlatch_pkg::*;
#(
  parameter int GATE_KIND = KIND_SWAP
) (
  input  logic       set_pin,
  input  logic       clr_pin,
  input  pair_t      cur,
  output pair_t      nxt,
  output logic [1:0] spill
);
  localparam logic CONST_ONE = 1'b1;

  generate
    if (GATE_KIND == KIND_SWAP) begin : g_swap
      logic a_side_y, a_side_z, b_side_y, b_side_z;
      // Q side: control Qbar, constant 1 against clear
      rl_cswap_gate u_gate_q (
        .ctl(cur.qn), .a(CONST_ONE), .b(clr_pin),
        .a_o(a_side_y), .b_o(a_side_z)
      );
      // Qbar side: control Q, constant 1 against set
      rl_cswap_gate u_gate_qn (
        .ctl(cur.q), .a(CONST_ONE), .b(set_pin),
        .a_o(b_side_y), .b_o(b_side_z)
      );
      always_comb begin
        nxt.q  = ~a_side_z;
        nxt.qn = ~b_side_z;
        spill  = {a_side_y, b_side_y};
      end
    end else begin : g_xor
      logic a_side_t, b_side_t;
      // Q side: controls set pin (active low) and Qbar, constant-1 target
      rl_cxor_gate u_gate_q (
        .c1(set_pin), .c2(cur.qn), .t(CONST_ONE), .t_o(a_side_t)
      );
      // Qbar side: controls clear pin (active low) and Q, constant-1 target
      rl_cxor_gate u_gate_qn (
        .c1(clr_pin), .c2(cur.q), .t(CONST_ONE), .t_o(b_side_t)
      );
      always_comb begin
        nxt.q  = a_side_t;
        nxt.qn = b_side_t;
        spill  = {cur.qn, cur.q};
      end
    end
  endgenerate
endmodule

// File: rtl/rl_step_track.sv
`timescale 1ns/1ps
module rl_step_track
  import revlatch_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  pair_t nxt,
  output pair_t state,
  output logic  settled
);
  pair_t prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PAIR_RESET;
      prev  <= PAIR_RESET;
    end else begin
      prev  <= state;
      state <= nxt;
    end
  end

  always_comb settled = (state == prev);
endmodule

// File: rtl/revlatch_stepper.sv
`timescale 1ns/1ps
module revlatch_stepper
  import revlatch_pkg::*;
#(
  parameter int GATE_KIND = KIND_SWAP
) (
  input  logic clk,
  input  logic rst,
  input  logic set_pin,
  input  logic clr_pin,
  output logic q,
  output logic q_n,
  output logic spill_a,
  output logic spill_b,
  output logic settled
);
  localparam logic ASSERT_LVL = (GATE_KIND == KIND_SWAP) ? 1'b1 : 1'b0;
  localparam logic BOTH_VAL   = (GATE_KIND == KIND_SWAP) ? 1'b0 : 1'b1;

  pair_t       state, nxt;
  logic [1:0]  spill;

  rl_gate_pair #(.GATE_KIND(GATE_KIND)) u_pair (
    .set_pin(set_pin), .clr_pin(clr_pin), .cur(state),
    .nxt(nxt), .spill(spill)
  );

  rl_step_track u_track (
    .clk(clk), .rst(rst), .nxt(nxt), .state(state), .settled(settled)
  );

  always_comb begin
    q       = state.q;
    q_n     = state.qn;
    spill_a = spill[1];
    spill_b = spill[0];
  end

  logic set_act, clr_act;
  always_comb begin
    set_act = (set_pin == ASSERT_LVL);
    clr_act = (clr_pin == ASSERT_LVL);
  end

  assert_reset_load_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (q == 1'b0 && q_n == 1'b1 && settled));

  assert_hold_keep_R4: assert property (@(posedge clk) disable iff (rst)
    (!set_act && !clr_act && q != q_n) |=> $stable({q, q_n}));

  assert_hold_toggle_R5: assert property (@(posedge clk) disable iff (rst)
    (!set_act && !clr_act && q == q_n) |=> (q == q_n && q != $past(q)));

  assert_clear_two_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_act && !set_act && $past(clr_act && !set_act) && !$past(rst))
      |=> (q == 1'b0 && q_n == 1'b1));

  assert_set_two_R6: assert property (@(posedge clk) disable iff (rst)
    (set_act && !clr_act && $past(set_act && !clr_act) && !$past(rst))
      |=> (q == 1'b1 && q_n == 1'b0));

  assert_both_R8: assert property (@(posedge clk) disable iff (rst)
    (set_act && clr_act) |=> (q == BOTH_VAL && q_n == BOTH_VAL));
endmodule

// File: tb/revlatch_stepper_bench.sv
`timescale 1ns/1ps
module revlatch_stepper_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst;
  logic sp0, cp0, sp1, cp1;
  logic q0, qn0, ga0, gb0, st0;
  logic q1, qn1, ga1, gb1, st1;

  revlatch_stepper #(.GATE_KIND(0)) u_revlatch_stepper (
    .clk(clk), .rst(rst), .set_pin(sp0), .clr_pin(cp0),
    .q(q0), .q_n(qn0), .spill_a(ga0), .spill_b(gb0), .settled(st0)
  );
  revlatch_stepper #(.GATE_KIND(1)) u_revlatch_stepper_xor (
    .clk(clk), .rst(rst), .set_pin(sp1), .clr_pin(cp1),
    .q(q1), .q_n(qn1), .spill_a(ga1), .spill_b(gb1), .settled(st1)
  );

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  logic cs, cr;
  logic [1:0] m_cur [2];
  logic [1:0] m_prev [2];

  task automatic chk(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // pair encoded {q, qn}; s and r are the logical (asserted = 1) commands
  function automatic logic [1:0] ref_next(input int k, input logic s, input logic r, input logic [1:0] st);
    if (k == 0) return {~(st[0] | r), ~(st[1] | s)};
    return {s | ~st[0], r | ~st[1]};
  endfunction

  function automatic logic [1:0] ref_spill(input int k, input logic s, input logic r, input logic [1:0] st);
    if (k == 0) return {~st[0] | r, ~st[1] | s};
    return {st[0], st[1]};
  endfunction

  task automatic drive(input logic s, input logic r);
    cs = s; cr = r;
    sp0 = s;  cp0 = r;
    sp1 = ~s; cp1 = ~r;
  endtask

  task automatic step();
    logic [1:0] a0, a1;
    @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      if (rst) begin
        m_prev[k] = 2'b01;
        m_cur[k]  = 2'b01;
      end else begin
        m_prev[k] = m_cur[k];
        m_cur[k]  = ref_next(k, cs, cr, m_cur[k]);
      end
    end
    #2;
    a0 = {q0, qn0};
    a1 = {q1, qn1};
    chk(a0 == m_cur[0], "R2", {2'b0, a0}, {2'b0, m_cur[0]});
    chk(st0 == (m_cur[0] == m_prev[0]), "R9", {3'b0, st0}, {3'b0, m_cur[0] == m_prev[0]});
    chk({ga0, gb0} == ref_spill(0, cs, cr, m_cur[0]), "R10", {2'b0, ga0, gb0}, {2'b0, ref_spill(0, cs, cr, m_cur[0])});
    chk(a1 == m_cur[1], "R3", {2'b0, a1}, {2'b0, m_cur[1]});
    chk(st1 == (m_cur[1] == m_prev[1]), "R9", {3'b0, st1}, {3'b0, m_cur[1] == m_prev[1]});
    chk({ga1, gb1} == ref_spill(1, cs, cr, m_cur[1]), "R10", {2'b0, ga1, gb1}, {2'b0, ref_spill(1, cs, cr, m_cur[1])});
  endtask

  function automatic logic [1:0] dut_pair(input int v);
    return (v == 0) ? {q0, qn0} : {q1, qn1};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [1:0] h [5];
    logic [1:0] tq, start, target;
    logic s, r;
    int slow_s, slow_r;
    void'($urandom(32'd20240607));
    rst = 1'b1;
    drive(1'b0, 1'b0);
    m_cur[0] = 2'b01; m_cur[1] = 2'b01; m_prev[0] = 2'b01; m_prev[1] = 2'b01;
    repeat (2) step();
    // R1: reset pair and flag on both variants
    chk({q0, qn0, q1, qn1} == 4'b0101, "R1", {q0, qn0, q1, qn1}, 4'b0101);
    chk({st0, st1} == 2'b11, "R1", {2'b0, st0, st1}, 4'b0011);
    rst = 1'b0;

    for (int v = 0; v < 2; v++) begin
      slow_s = 0; slow_r = 0;
      for (int c = 0; c < 16; c++) begin
        s  = c[3];
        r  = c[2];
        tq = c[1:0];
        rst = 1'b1; drive(1'b0, 1'b0); step(); rst = 1'b0;
        if (tq == 2'b10) begin
          drive(1'b1, 1'b0); repeat (2) step();
        end else if (tq == 2'b00 || tq == 2'b11) begin
          drive(1'b1, 1'b1); step();
          drive(1'b0, 1'b0);
          for (int i = 0; i < 2; i++) if (m_cur[v] != tq) step();
        end
        start = dut_pair(v);
        drive(s, r);
        h[0] = start;
        for (int i = 1; i < 5; i++) begin
          step();
          h[i] = dut_pair(v);
        end
        if (s != r) begin
          target = s ? 2'b10 : 2'b01;
          chk(h[2] == target && h[3] == target, "R6", {h[2], h[3]}, {target, target});
          if (h[1] != target) begin
            if (s) slow_s++; else slow_r++;
          end
        end else if (!s) begin
          if (start[1] != start[0])
            chk(h[1] == start && h[4] == start, "R4", {h[1], h[4]}, {start, start});
          else
            chk(h[1] == ~start && h[2] == start && h[3] == ~start, "R5",
                {h[1], h[2]}, {~start, start});
        end else begin
          target = (v == 0) ? 2'b00 : 2'b11;
          chk(h[1] == target && h[4] == target, "R8", {h[1], h[4]}, {target, target});
        end
      end
      // R7: exactly two slow starts per command per variant
      chk(slow_s == 2, "R7", 4'(slow_s), 4'd2);
      chk(slow_r == 2, "R7", 4'(slow_r), 4'd2);
    end

    for (int i = 0; i < 600; i++) begin
      rst = (($urandom % 40) == 0);
      drive(1'($urandom % 2), 1'($urandom % 2));
      step();
    end
    rst = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule